// File: doc/BRIEF.md
# Timer Accumulator Period Marker

This block marks the end of each programmed time interval. A host loads a step value as two half-width words. A control input then moves that value into a working increment register. On every clock edge an accumulator adds the increment to itself modulo 2^ACC_W. Each wrap past full scale produces a one-clock active-low pulse on the carry output. With a constant step N the pulses arrive on average every 2^ACC_W / N clocks.

Two active-low controls steer the block, and each is captured in a flop before it acts. The load control copies the staged halves into the working increment and leaves the running accumulator value alone, so a rate change does not break the phase. The init control does two things: it also loads the increment, and it forces the accumulator feedback to zero, so the count restarts from the increment itself. The host decode lies outside the block and supplies one write strobe per half.

Top module: `period_marker`

## Requirements
- R1: During and after reset the carry output is high. The working increment and the accumulator are zero, so no pulse appears until an increment is loaded.
- R2: A high `wr_hi` at a clock edge writes `wr_data` into the upper staged half (bits ACC_W-1 down to ACC_W/2). A high `wr_lo` writes the lower half. A half that is not strobed keeps its value.
- R3: Writing the staged halves has no effect on the running count while both registered controls are high.
- R4: `inc_load_n` is captured at one edge. At the next edge the working increment takes the staged value. The accumulator keeps its value at that edge and adds the old increment, then goes on with the new increment.
- R5: With the init control released, the accumulator adds the working increment at every edge, modulo 2^ACC_W.
- R6: `carry_n` is low for exactly the cycle after each edge at which the addition overflows, and high after every edge without overflow. Overflows at consecutive edges give consecutive low cycles.
- R7: `init_n` is captured at one edge. While it is held in that flop as low, the working increment loads from the staged halves, the accumulator takes the increment plus zero, and no carry is produced.
- R8: With a constant increment N, the number of pulses after the accumulator total reaches T (counted from a restart) equals floor(T / 2^ACC_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_hi | input | 1 | Write strobe for the upper staged half |
| wr_lo | input | 1 | Write strobe for the lower staged half |
| wr_data | input | ACC_W/2 | Data for the half being written |
| inc_load_n | input | 1 | Active-low transfer of the staged halves into the working increment |
| init_n | input | 1 | Active-low restart: loads the increment and zeroes the feedback |
| carry_n | output | 1 | Active-low registered wrap pulse |

## Verification
The block is built with an 8-bit accumulator. Every nonzero increment from 1 to 255 is tried, each started through the init control. The small values show sparse single-cycle pulses, and the values above half scale show consecutive low cycles, so the two cases separate a correct carry register from one that is stretched or held. For each increment, the pulse count over a run is compared with the floor of the exact total sum, which exposes any step lost or repeated around the restart. A further run writes one half only and then loads without init. This separates staging that leaks into the count, a wrongly combined half, and a load that disturbs the accumulator phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Active-low control pair as seen by the accumulator core
    typedef struct packed {
        logic load_n;
        logic init_n;
    } tmr_ctl_t;

    localparam tmr_ctl_t TMR_CTL_IDLE = '{load_n: 1'b1, init_n: 1'b1};

endpackage

// File: rtl/tmr_stage.sv
module tmr_stage #(
    parameter int HALF_W     = 16,
    parameter int NUM_HALVES = 2,
    localparam int STAGE_W   = HALF_W * NUM_HALVES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_HALVES-1:0] wr_en,
    input  logic [HALF_W-1:0]     wr_data,
    output logic [STAGE_W-1:0]    staged
);

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        logic [HALF_W-1:0] half_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (wr_en[g]) begin
                half_q <= wr_data;
            end
        end

        assign staged[g*HALF_W +: HALF_W] = half_q;

        AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[g] |=> $stable(staged[g*HALF_W +: HALF_W])); // R2
    end

endmodule

// File: rtl/tmr_ctl_sync.sv
module tmr_ctl_sync
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  tmr_ctl_t ctl_raw,
    output tmr_ctl_t ctl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= TMR_CTL_IDLE;
        end else begin
            ctl_q <= ctl_raw;
        end
    end

endmodule

// File: rtl/tmr_accum.sv
module tmr_accum
    import tmr_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_ctl_t         ctl_q,
    input  logic [ACC_W-1:0] staged,
    output logic             carry_n
);

    logic [ACC_W-1:0] inc_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] feedback;
    logic [ACC_W:0]   sum;
    logic             inc_take;

    assign inc_take = !ctl_q.load_n || !ctl_q.init_n;
    assign feedback = ctl_q.init_n ? acc_q : '0;
    assign sum      = {1'b0, feedback} + {1'b0, inc_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_q <= '0;
        end else if (inc_take) begin
            inc_q <= staged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_n <= 1'b1;
        end else begin
            acc_q   <= sum[ACC_W-1:0];
            carry_n <= ~sum[ACC_W];
        end
    end

    AST_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.load_n && ctl_q.init_n) |=> $stable(inc_q)); // R3

    AST_INC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.load_n && ctl_q.init_n) |=> (inc_q == $past(staged))); // R4

    AST_WRAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.init_n |=> ((!carry_n) == (acc_q < $past(acc_q)))); // R6

    AST_INIT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.init_n |=> carry_n); // R7

endmodule

// File: rtl/period_marker.sv
module period_marker
    import tmr_pkg::*;
#(
    parameter int ACC_W = 32,
    localparam int HALF_W = ACC_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              inc_load_n,
    input  logic              init_n,
    output logic              carry_n
);

    localparam int NUM_HALVES = 2;

    logic [NUM_HALVES-1:0] wr_en;
    logic [ACC_W-1:0]      staged;
    tmr_ctl_t              ctl_raw;
    tmr_ctl_t              ctl_q;

    assign wr_en          = {wr_hi, wr_lo};
    assign ctl_raw.load_n = inc_load_n;
    assign ctl_raw.init_n = init_n;

    tmr_stage #(
        .HALF_W     (HALF_W),
        .NUM_HALVES (NUM_HALVES)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .staged  (staged)
    );

    tmr_ctl_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_raw (ctl_raw),
        .ctl_q   (ctl_q)
    );

    tmr_accum #(
        .ACC_W (ACC_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_q   (ctl_q),
        .staged  (staged),
        .carry_n (carry_n)
    );

endmodule

// File: tb/tb_period_marker.sv
module tb_period_marker;

    localparam int W    = 8;
    localparam int HW   = W / 2;
    localparam int M    = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_hi = 1'b0;
    logic          wr_lo = 1'b0;
    logic [HW-1:0] wr_data = '0;
    logic          inc_load_n = 1'b1;
    logic          init_n = 1'b1;
    logic          carry_n;

    int     checks = 0;
    int     failures = 0;
    longint tot = 0;
    int     pulses = 0;
    bit     done = 1'b0;

    always #10 clk = ~clk;

    period_marker #(.ACC_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hi      (wr_hi),
        .wr_lo      (wr_lo),
        .wr_data    (wr_data),
        .inc_load_n (inc_load_n),
        .init_n     (init_n),
        .carry_n    (carry_n)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One edge passes; sample at the following falling edge
    task automatic skip_edge();
        @(negedge clk);
    endtask

    // One edge adding 'add' to the running total; carry expected on wrap
    task automatic run_edge(input int add, input string req);
        longint old;
        old = tot;
        tot = tot + add;
        @(negedge clk);
        check(req, carry_n, ((tot / M) > (old / M)) ? 0 : 1);
        if (!carry_n) pulses++;
    endtask

    // Write both halves, then restart through init; ends after the
    // edge at which the accumulator holds n
    task automatic start(input int n);
        wr_hi = 1'b1; wr_data = HW'(n >> HW);
        skip_edge();
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = HW'(n);
        skip_edge();
        wr_lo = 1'b0; init_n = 1'b0;
        skip_edge();
        skip_edge();
        init_n = 1'b1;
        skip_edge();
        check("R7 no carry under init", carry_n, 1);
        tot = n;
        pulses = 0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state and no pulses with a zero increment
        repeat (2) @(negedge clk);
        check("R1 carry high in reset", carry_n, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            skip_edge();
            check("R1 idle after reset", carry_n, 1);
        end

        // R5 R6 R8: sweep every nonzero increment
        for (int n = 1; n < M; n++) begin
            int k;
            start(n);
            k = 2 * M / n + 3;
            for (int e = 0; e < k; e++) run_edge(n, "R6 carry pattern");
            check("R8 pulse count", pulses, tot / M);
            check("R5 total reached", tot, longint'(n) * (k + 1));
        end

        // R2 R3 R4: partial write, then phase-continuous load
        start(8'h25);
        for (int e = 0; e < 20; e++) run_edge(8'h25, "R5 before reload");
        wr_lo = 1'b1; wr_data = 4'hA;
        run_edge(8'h25, "R3 staging write ignored");
        wr_lo = 1'b0;
        for (int e = 0; e < 10; e++) run_edge(8'h25, "R3 old rate kept");
        inc_load_n = 1'b0;
        run_edge(8'h25, "R4 load captured");
        inc_load_n = 1'b1;
        run_edge(8'h25, "R4 old increment at load edge");
        pulses = 0;
        begin
            longint base;
            base = tot;
            for (int e = 0; e < 40; e++) run_edge(8'h2A, "R2 R4 new rate");
            check("R2 combined halves", tot - base, 40 * 8'h2A);
        end

        // R7: init mid-run restarts from the increment
        start(8'hC3);
        for (int e = 0; e < 12; e++) run_edge(8'hC3, "R7 after restart");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule